// File: doc/BRIEF.md
# Voltage/Frequency Operating Point Controller

This block is the digital side of an open-loop supply and clock scaling system. Software states how much throughput the next task needs as an 8-bit level. The block searches a small table of characterized operating points for the slowest point whose frequency code still meets that level. It then drives a frequency code to an external clock synthesizer and a voltage code to an external supply regulator. Each side answers with a one-cycle acknowledge.

Changes are ordered so that the logic never runs faster than its supply allows. When the point goes up, the voltage is raised first and the frequency follows only after the regulator acknowledges. When the point goes down, the frequency is lowered first and the voltage follows only after the synthesizer reports lock. The table is fixed at reset to worst-case values and can be rewritten only while the block is idle. Nothing senses process, voltage or temperature, and nothing adjusts the table at run time. A request that arrives during a transition is held in a single slot and is served once the transition completes.

Top module: `opp_ctrl`

## Requirements
- R1: After reset, `pll_freq` is 30, `vreg_volt` is 60 and `cur_idx` is 0. `busy`, `done`, `ovf_flag`, `pll_req` and `vreg_req` are all 0. Entry i of the table resets to frequency code 30+30*i and voltage code 60+20*i, for i from 0 to 7.
- R2: A request selects the lowest table index whose frequency code is greater than or equal to `perf_level`. The table is assumed to be sorted by ascending frequency.
- R3: If no entry meets the level, index 7 is selected and `ovf_flag` is set. `ovf_flag` stays set until reset.
- R4: Moving to a higher index first raises `vreg_req` with the new voltage code. `pll_req` rises with the new frequency code only after `vreg_ack` has been received.
- R5: Moving to a lower index first raises `pll_req` with the new frequency code. `vreg_req` rises with the new voltage code only after `pll_ack` has been received.
- R6: A request whose selected index equals `cur_idx` causes no handshake and produces a `done` pulse on the next cycle.
- R7: When the last acknowledge of a transition is taken, `done` pulses for one cycle, `cur_idx` takes the new index, and both request outputs are low.
- R8: `busy` is high from the cycle after a request is accepted until the transition completes, and it stays high while a request is waiting.
- R9: A request that arrives during a transition is held and served after that transition. If several arrive, only the most recent one is kept.
- R10: A write through `tbl_wr_en` replaces the entry at `tbl_wr_idx` only when `busy` is low. A write while busy has no effect.
- R11: While `pll_req` or `vreg_req` is high and no acknowledge has arrived, that request stays high and its code does not change.
- R12: `pll_req` and `vreg_req` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tbl_wr_en | input | 1 | Table write strobe, honoured only while not busy |
| tbl_wr_idx | input | 3 | Table entry to write |
| tbl_wr_freq | input | 8 | Frequency code to store |
| tbl_wr_volt | input | 8 | Voltage code to store |
| perf_valid | input | 1 | Performance request strobe |
| perf_level | input | 8 | Required throughput level |
| pll_req | output | 1 | Frequency change request to the clock synthesizer |
| pll_freq | output | 8 | Target frequency code |
| pll_ack | input | 1 | Synthesizer lock acknowledge |
| vreg_req | output | 1 | Voltage change request to the regulator |
| vreg_volt | output | 8 | Target voltage code |
| vreg_ack | input | 1 | Regulator settle acknowledge |
| busy | output | 1 | Transition in progress or request waiting |
| done | output | 1 | One-cycle pulse when a transition completes |
| cur_idx | output | 3 | Index of the operating point now in force |
| ovf_flag | output | 1 | Sticky flag: a request exceeded the top entry |

## Verification
The bench uses several request patterns, each aimed at a different fault:
- A level between two entries and a level one above an entry tell a correct lowest-meeting search apart from an off-by-one or a strict comparison.
- A level equal to the current entry shows whether the no-handshake path is taken.
- Upward and downward moves show whether the voltage/frequency order follows the direction.
- A level beyond the top entry, followed by a low level, tells saturation and stickiness apart from a flag that clears itself.
- A burst of two requests during a transition tells latest-wins holding apart from dropping or queueing.
- Table writes made idle and busy, each followed by a probing request, show whether the idle-only write rule is applied.

// File: rtl/opp_pkg.sv
package opp_pkg;
  parameter int CODE_W = 8;

  typedef struct packed {
    logic [CODE_W-1:0] freq;
    logic [CODE_W-1:0] volt;
  } opp_t;

  typedef enum logic [2:0] {
    SQ_IDLE,
    SQ_VUP,
    SQ_FUP,
    SQ_FDN,
    SQ_VDN
  } seq_state_e;

  function automatic logic [CODE_W-1:0] ramp(input int unsigned base,
                                             input int unsigned step,
                                             input int unsigned idx);
    int unsigned tmp;
    tmp = base + step * idx;
    return tmp[CODE_W-1:0];
  endfunction
endpackage

// File: rtl/opp_table.sv
module opp_table #(
  parameter int N_ENT  = 8,
  parameter int F_BASE = 30,
  parameter int F_STEP = 30,
  parameter int V_BASE = 60,
  parameter int V_STEP = 20,
  localparam int IDX_W = $clog2(N_ENT)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        wr_en,
  input  logic [IDX_W-1:0]            wr_idx,
  input  opp_pkg::opp_t               wr_entry,
  output opp_pkg::opp_t [N_ENT-1:0]   ent_o
);
  for (genvar g = 0; g < N_ENT; g++) begin : g_ent
    opp_pkg::opp_t q;
    logic          we;
    assign we = wr_en && (wr_idx == IDX_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        q.freq <= opp_pkg::ramp(F_BASE, F_STEP, g);
        q.volt <= opp_pkg::ramp(V_BASE, V_STEP, g);
      end else if (we) begin
        q <= wr_entry;
      end
    end
    assign ent_o[g] = q;
  end
endmodule

// File: rtl/opp_lookup.sv
module opp_lookup #(
  parameter int N_ENT  = 8,
  localparam int IDX_W = $clog2(N_ENT),
  localparam int CW    = opp_pkg::CODE_W
) (
  input  opp_pkg::opp_t [N_ENT-1:0] ent_i,
  input  logic [CW-1:0]             level_i,
  output logic [IDX_W-1:0]          idx_o,
  output logic                      ovf_o
);
  logic [N_ENT-1:0] hit;

  for (genvar g = 0; g < N_ENT; g++) begin : g_cmp
    assign hit[g] = (ent_i[g].freq >= level_i);
  end

  always_comb begin
    idx_o = IDX_W'(N_ENT - 1);
    for (int i = N_ENT - 1; i >= 0; i--) begin
      if (hit[i]) idx_o = IDX_W'(i);
    end
    ovf_o = ~|hit;
  end
endmodule

// File: rtl/opp_seq.sv
module opp_seq #(
  parameter int N_ENT = 8,
  parameter logic [opp_pkg::CODE_W-1:0] RST_FREQ = '0,
  parameter logic [opp_pkg::CODE_W-1:0] RST_VOLT = '0,
  localparam int IDX_W = $clog2(N_ENT),
  localparam int CW    = opp_pkg::CODE_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start_i,
  input  logic [IDX_W-1:0]   start_idx_i,
  input  opp_pkg::opp_t      start_ent_i,
  input  logic               pll_ack_i,
  input  logic               vreg_ack_i,
  output logic               pll_req_o,
  output logic [CW-1:0]      pll_freq_o,
  output logic               vreg_req_o,
  output logic [CW-1:0]      vreg_volt_o,
  output logic               done_o,
  output logic [IDX_W-1:0]   cur_idx_o,
  output logic               idle_o
);
  import opp_pkg::*;

  seq_state_e         state_q, state_d;
  opp_t               tgt_q, tgt_d;
  logic [IDX_W-1:0]   tgt_idx_q, tgt_idx_d, cur_q, cur_d;
  logic               pll_req_q, pll_req_d, vreg_req_q, vreg_req_d;
  logic [CW-1:0]      freq_q, freq_d, volt_q, volt_d;
  logic               done_q, done_d;

  always_comb begin
    state_d    = state_q;
    tgt_d      = tgt_q;
    tgt_idx_d  = tgt_idx_q;
    cur_d      = cur_q;
    pll_req_d  = pll_req_q;
    vreg_req_d = vreg_req_q;
    freq_d     = freq_q;
    volt_d     = volt_q;
    done_d     = 1'b0;
    unique case (state_q)
      SQ_IDLE: begin
        if (start_i) begin
          tgt_d     = start_ent_i;
          tgt_idx_d = start_idx_i;
          if (start_idx_i > cur_q) begin
            volt_d     = start_ent_i.volt;
            vreg_req_d = 1'b1;
            state_d    = SQ_VUP;
          end else if (start_idx_i < cur_q) begin
            freq_d    = start_ent_i.freq;
            pll_req_d = 1'b1;
            state_d   = SQ_FDN;
          end else begin
            done_d = 1'b1;
          end
        end
      end
      SQ_VUP: begin
        if (vreg_ack_i) begin
          vreg_req_d = 1'b0;
          freq_d     = tgt_q.freq;
          pll_req_d  = 1'b1;
          state_d    = SQ_FUP;
        end
      end
      SQ_FUP: begin
        if (pll_ack_i) begin
          pll_req_d = 1'b0;
          cur_d     = tgt_idx_q;
          done_d    = 1'b1;
          state_d   = SQ_IDLE;
        end
      end
      SQ_FDN: begin
        if (pll_ack_i) begin
          pll_req_d  = 1'b0;
          volt_d     = tgt_q.volt;
          vreg_req_d = 1'b1;
          state_d    = SQ_VDN;
        end
      end
      SQ_VDN: begin
        if (vreg_ack_i) begin
          vreg_req_d = 1'b0;
          cur_d      = tgt_idx_q;
          done_d     = 1'b1;
          state_d    = SQ_IDLE;
        end
      end
      default: state_d = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= SQ_IDLE;
      tgt_q      <= '0;
      tgt_idx_q  <= '0;
      cur_q      <= '0;
      pll_req_q  <= 1'b0;
      vreg_req_q <= 1'b0;
      freq_q     <= RST_FREQ;
      volt_q     <= RST_VOLT;
      done_q     <= 1'b0;
    end else begin
      state_q    <= state_d;
      tgt_q      <= tgt_d;
      tgt_idx_q  <= tgt_idx_d;
      cur_q      <= cur_d;
      pll_req_q  <= pll_req_d;
      vreg_req_q <= vreg_req_d;
      freq_q     <= freq_d;
      volt_q     <= volt_d;
      done_q     <= done_d;
    end
  end

  assign pll_req_o   = pll_req_q;
  assign pll_freq_o  = freq_q;
  assign vreg_req_o  = vreg_req_q;
  assign vreg_volt_o = volt_q;
  assign done_o      = done_q;
  assign cur_idx_o   = cur_q;
  assign idle_o      = (state_q == SQ_IDLE);
endmodule

// File: rtl/opp_ctrl.sv
module opp_ctrl #(
  parameter int N_ENT  = 8,
  parameter int F_BASE = 30,
  parameter int F_STEP = 30,
  parameter int V_BASE = 60,
  parameter int V_STEP = 20
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       tbl_wr_en,
  input  logic [$clog2(N_ENT)-1:0]   tbl_wr_idx,
  input  logic [7:0]                 tbl_wr_freq,
  input  logic [7:0]                 tbl_wr_volt,
  input  logic                       perf_valid,
  input  logic [7:0]                 perf_level,
  output logic                       pll_req,
  output logic [7:0]                 pll_freq,
  input  logic                       pll_ack,
  output logic                       vreg_req,
  output logic [7:0]                 vreg_volt,
  input  logic                       vreg_ack,
  output logic                       busy,
  output logic                       done,
  output logic [$clog2(N_ENT)-1:0]   cur_idx,
  output logic                       ovf_flag
);
  localparam int IDX_W = $clog2(N_ENT);
  localparam int CW    = opp_pkg::CODE_W;
  localparam logic [CW-1:0] RST_F = opp_pkg::ramp(F_BASE, F_STEP, 0);
  localparam logic [CW-1:0] RST_V = opp_pkg::ramp(V_BASE, V_STEP, 0);

  opp_pkg::opp_t [N_ENT-1:0] ent;
  opp_pkg::opp_t             wr_entry;
  logic                      wr_ok;
  logic [IDX_W-1:0]          lk_idx;
  logic                      lk_ovf;
  logic [CW-1:0]             lvl_sel;
  logic                      seq_idle, start;
  logic                      pend_q, pend_d, ovf_q, ovf_d;
  logic [CW-1:0]             plvl_q, plvl_d;

  assign wr_entry = '{freq: tbl_wr_freq, volt: tbl_wr_volt};
  assign wr_ok    = tbl_wr_en && !busy;

  opp_table #(
    .N_ENT(N_ENT), .F_BASE(F_BASE), .F_STEP(F_STEP),
    .V_BASE(V_BASE), .V_STEP(V_STEP)
  ) u_table (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_ok), .wr_idx(tbl_wr_idx),
    .wr_entry(wr_entry), .ent_o(ent)
  );

  assign lvl_sel = perf_valid ? perf_level : plvl_q;

  opp_lookup #(.N_ENT(N_ENT)) u_lookup (
    .ent_i(ent), .level_i(lvl_sel), .idx_o(lk_idx), .ovf_o(lk_ovf)
  );

  assign start = seq_idle && (perf_valid || pend_q);

  always_comb begin
    pend_d = pend_q;
    plvl_d = plvl_q;
    ovf_d  = ovf_q | (start & lk_ovf);
    if (start) begin
      pend_d = 1'b0;
    end else if (perf_valid) begin
      pend_d = 1'b1;
      plvl_d = perf_level;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      plvl_q <= '0;
      ovf_q  <= 1'b0;
    end else begin
      pend_q <= pend_d;
      plvl_q <= plvl_d;
      ovf_q  <= ovf_d;
    end
  end

  opp_seq #(.N_ENT(N_ENT), .RST_FREQ(RST_F), .RST_VOLT(RST_V)) u_seq (
    .clk(clk), .rst_n(rst_n), .start_i(start), .start_idx_i(lk_idx),
    .start_ent_i(ent[lk_idx]), .pll_ack_i(pll_ack), .vreg_ack_i(vreg_ack),
    .pll_req_o(pll_req), .pll_freq_o(pll_freq), .vreg_req_o(vreg_req),
    .vreg_volt_o(vreg_volt), .done_o(done), .cur_idx_o(cur_idx),
    .idle_o(seq_idle)
  );

  assign busy     = !seq_idle || pend_q;
  assign ovf_flag = ovf_q;
endmodule

// File: rtl/opp_ctrl_chk.sv
module opp_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       pll_req,
  input logic       pll_ack,
  input logic [7:0] pll_freq,
  input logic       vreg_req,
  input logic       vreg_ack,
  input logic [7:0] vreg_volt,
  input logic       busy,
  input logic       done,
  input logic       ovf_flag
);
  AST_NO_DUAL_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    !(pll_req && vreg_req)); // R12
  AST_PLL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (pll_req && !pll_ack) |=> (pll_req && $stable(pll_freq))); // R11
  AST_VREG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (vreg_req && !vreg_ack) |=> (vreg_req && $stable(vreg_volt))); // R11
  AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!pll_req && !vreg_req)); // R7
  AST_REQ_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (pll_req || vreg_req) |-> busy); // R8
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_flag |=> ovf_flag); // R3
endmodule

bind opp_ctrl opp_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .pll_req(pll_req), .pll_ack(pll_ack),
  .pll_freq(pll_freq), .vreg_req(vreg_req), .vreg_ack(vreg_ack),
  .vreg_volt(vreg_volt), .busy(busy), .done(done), .ovf_flag(ovf_flag)
);

// File: tb/test_opp_ctrl.sv
`timescale 1ns/1ps
module test_opp_ctrl;
  localparam int LAT = 3;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tbl_wr_en = 1'b0;
  logic [2:0] tbl_wr_idx = '0;
  logic [7:0] tbl_wr_freq = '0, tbl_wr_volt = '0;
  logic       perf_valid = 1'b0;
  logic [7:0] perf_level = '0;
  logic       pll_req, vreg_req, busy, done, ovf_flag;
  logic [7:0] pll_freq, vreg_volt;
  logic       pll_ack = 1'b0, vreg_ack = 1'b0;
  logic [2:0] cur_idx;

  int checks = 0, fails = 0;
  int cyc = 0, v_rise = 0, p_rise = 0, done_cnt = 0, dual_cnt = 0, unstable = 0;
  int v_code = 0, p_code = 0, pcnt = 0, vcnt = 0;
  logic pr_prev = 0, vr_prev = 0;
  logic [7:0] pf_prev = 0, vv_prev = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  opp_ctrl i_opp_ctrl (
    .clk(clk), .rst_n(rst_n), .tbl_wr_en(tbl_wr_en), .tbl_wr_idx(tbl_wr_idx),
    .tbl_wr_freq(tbl_wr_freq), .tbl_wr_volt(tbl_wr_volt),
    .perf_valid(perf_valid), .perf_level(perf_level),
    .pll_req(pll_req), .pll_freq(pll_freq), .pll_ack(pll_ack),
    .vreg_req(vreg_req), .vreg_volt(vreg_volt), .vreg_ack(vreg_ack),
    .busy(busy), .done(done), .cur_idx(cur_idx), .ovf_flag(ovf_flag)
  );

  // acknowledge models and event monitor
  always @(negedge clk) begin
    if (pll_req && !pll_ack) begin
      if (pcnt == LAT) begin pll_ack = 1'b1; pcnt = 0; end else pcnt++;
    end else begin pll_ack = 1'b0; pcnt = 0; end
    if (vreg_req && !vreg_ack) begin
      if (vcnt == LAT) begin vreg_ack = 1'b1; vcnt = 0; end else vcnt++;
    end else begin vreg_ack = 1'b0; vcnt = 0; end
    cyc++;
    if (vreg_req && !vr_prev) begin v_rise = cyc; v_code = vreg_volt; end
    if (pll_req && !pr_prev) begin p_rise = cyc; p_code = pll_freq; end
    if (done) done_cnt++;
    if (pll_req && vreg_req) dual_cnt++;
    if (pr_prev && pll_req && pll_freq != pf_prev) unstable++;
    if (vr_prev && vreg_req && vreg_volt != vv_prev) unstable++;
    pr_prev = pll_req; vr_prev = vreg_req; pf_prev = pll_freq; vv_prev = vreg_volt;
  end

  task automatic step();
    @(negedge clk); #1;
  endtask

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic do_req(int lvl);
    step();
    v_rise = 0; p_rise = 0;
    perf_valid = 1'b1; perf_level = 8'(lvl);
    step();
    perf_valid = 1'b0;
  endtask

  task automatic wait_cnt(int n);
    for (int i = 0; i < 300 && done_cnt < n; i++) step();
  endtask

  task automatic t_reset();
    chk("R1 pll_freq", pll_freq, 30);
    chk("R1 vreg_volt", vreg_volt, 60);
    chk("R1 cur_idx", cur_idx, 0);
    chk("R1 busy", busy, 0);
    chk("R1 ovf", ovf_flag, 0);
    chk("R1 reqs", {pll_req, vreg_req, done}, 0);
  endtask

  task automatic t_up();
    int base = done_cnt;
    do_req(100);
    chk("R8 busy after accept", busy, 1);
    wait_cnt(base + 1);
    chk("R2 cur_idx", cur_idx, 3);
    chk("R4 volt raised", v_rise > 0, 1);
    chk("R4 volt before freq", p_rise > v_rise, 1);
    chk("R4 volt code", v_code, 120);
    chk("R4 freq code", p_code, 120);
    step();
    chk("R7 done count", done_cnt, base + 1);
    chk("R8 busy low after", busy, 0);
  endtask

  task automatic t_down();
    int base = done_cnt;
    do_req(31);
    wait_cnt(base + 1);
    chk("R2 just above entry", cur_idx, 1);
    chk("R5 freq lowered", p_rise > 0, 1);
    chk("R5 freq before volt", v_rise > p_rise, 1);
    chk("R5 freq code", p_code, 60);
    chk("R5 volt code", v_code, 80);
  endtask

  task automatic t_same();
    int base = done_cnt;
    do_req(60);
    wait_cnt(base + 1);
    chk("R6 done", done_cnt, base + 1);
    chk("R6 no handshake", (v_rise != 0) || (p_rise != 0), 0);
    chk("R6 cur_idx", cur_idx, 1);
  endtask

  task automatic t_ovf();
    int base = done_cnt;
    do_req(250);
    wait_cnt(base + 1);
    chk("R3 saturate idx", cur_idx, 7);
    chk("R3 freq", pll_freq, 240);
    chk("R3 volt", vreg_volt, 200);
    chk("R3 flag set", ovf_flag, 1);
    do_req(10);
    wait_cnt(base + 2);
    chk("R3 low idx", cur_idx, 0);
    chk("R3 flag sticky", ovf_flag, 1);
  endtask

  task automatic t_pending();
    int base = done_cnt;
    do_req(200);
    do_req(90);
    do_req(150);
    wait_cnt(base + 1);
    chk("R9 first idx", cur_idx, 6);
    chk("R8 busy with pending", busy, 1);
    wait_cnt(base + 2);
    chk("R9 latest served", cur_idx, 4);
    chk("R9 freq", pll_freq, 150);
    chk("R9 volt", vreg_volt, 140);
    repeat (20) step();
    chk("R9 older dropped", done_cnt, base + 2);
    chk("R8 idle at end", busy, 0);
  endtask

  task automatic t_table();
    int base = done_cnt;
    step();
    tbl_wr_en = 1'b1; tbl_wr_idx = 3'd5; tbl_wr_freq = 8'd175; tbl_wr_volt = 8'd155;
    step();
    tbl_wr_en = 1'b0;
    do_req(160);
    wait_cnt(base + 1);
    chk("R10 idle write idx", cur_idx, 5);
    chk("R10 idle write freq", pll_freq, 175);
    chk("R10 idle write volt", vreg_volt, 155);
    do_req(0);
    step();
    tbl_wr_en = 1'b1; tbl_wr_idx = 3'd5; tbl_wr_freq = 8'd177; tbl_wr_volt = 8'd157;
    step();
    tbl_wr_en = 1'b0;
    wait_cnt(base + 2);
    chk("R10 down idx", cur_idx, 0);
    do_req(176);
    wait_cnt(base + 3);
    chk("R10 busy write ignored idx", cur_idx, 6);
    chk("R10 busy write ignored freq", pll_freq, 210);
    chk("R10 busy write ignored volt", vreg_volt, 180);
  endtask

  initial begin
    repeat (3) step();
    rst_n = 1'b1;
    step();
    t_reset();
    t_up();
    t_down();
    t_same();
    t_ovf();
    t_pending();
    t_table();
    chk("R12 no dual request", dual_cnt, 0);
    chk("R11 codes stable under request", unstable, 0);
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #400000;
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule